// File: doc/BRIEF.md
# DMA Graceful Stop and Transmit Poll Controller

This block sits behind the DMA control register of an Ethernet controller. Software writes the control register to ask the transmit or receive DMA path to stop gracefully. If the path has no frame in flight, the stop finishes at once. If a frame is in flight, the stop waits for that frame's end-of-frame pulse. Either way, the block reports completion with a one-cycle event pulse on that path's done output.

The same register also controls a periodic poll of transmit ring 0. Any control write that leaves the poll-suppress bit clear restarts the poll timer with a full period. Each time the timer expires, it re-arms unless polling has since been suppressed. It emits a poll strobe only while the transmit stop bit is clear. The period is derived from the clock rate and a poll rate of 100 per second. Descriptor processing lies outside the block.

Top module: `dma_stop_poll_ctrl`

## Requirements
- R1: After reset, all outputs are low, and the poll timer stays idle until a control write with `ctl_wop` = 0 arrives. With no such write, no `poll_tx0` strobe ever appears.
- R2: A control write with `ctl_grs` = 1 while `rx_busy` = 0 makes `rx_stop_done` high for exactly one cycle, in the cycle right after the write.
- R3: A control write with `ctl_grs` = 1 while `rx_busy` = 1 gives no pulse at the write. The stop stays pending, and `rx_stop_done` pulses for one cycle in the cycle after the next `rx_eof` pulse.
- R4: `ctl_gts` with `tx_busy` and `tx_eof` behaves in the same way and drives `tx_stop_done`. This covers both the immediate and the deferred case.
- R5: A deferred stop produces exactly one pulse. Later end-of-frame pulses produce none while the request bit stays set and no new write arrives.
- R6: A control write with the stop bit at 0 withdraws a pending stop on that path. A later end-of-frame pulse then produces no completion pulse.
- R7: A control write with `ctl_wop` = 0 restarts the poll timer. The timer period is PERIOD = CLK_HZ/POLL_HZ cycles.
  - With `ctl_gts` = 0, `poll_tx0` pulses for one cycle exactly PERIOD cycles after the write cycle.
  - It then pulses again every PERIOD cycles.
- R8: While the stored `ctl_gts` is 1, each timer expiry re-arms the timer but emits no `poll_tx0` strobe.
- R9: A control write with `ctl_wop` = 1 does not stop a running timer at once. At the timer's next expiry the timer stops without a strobe, and no strobes follow.
- R10: A control write with `ctl_wop` = 0 that arrives while the timer is counting restarts the full period. The next strobe comes PERIOD cycles after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_gts | input | 1 | Write data: graceful transmit stop request |
| ctl_grs | input | 1 | Write data: graceful receive stop request |
| ctl_wop | input | 1 | Write data: poll suppress (1 = no polling) |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_eof | input | 1 | Transmit end-of-frame pulse |
| rx_eof | input | 1 | Receive end-of-frame pulse |
| tx_stop_done | output | 1 | Transmit stop complete event pulse |
| rx_stop_done | output | 1 | Receive stop complete event pulse |
| poll_tx0 | output | 1 | Poll strobe for transmit ring 0 |

## Verification
A pending-stop flag stuck high would show as a stray done pulse on the first end-of-frame pulse after a withdrawn request. A pending-stop flag lost would show as a missing pulse one cycle after the end-of-frame pulse. A wrong reload value or a timer that keeps running after suppression shows up within one or two poll periods. It appears as a strobe at the wrong cycle count, or as a strobe where none is allowed. For that reason the bench times every strobe against the write cycle and watches several periods after each mode change.

// File: rtl/dma_stop_poll_pkg.sv
package dma_stop_poll_pkg;
  typedef struct packed {
    logic tx_stop;
    logic rx_stop;
    logic no_poll;
  } dma_ctl_t;
endpackage

// File: rtl/stop_unit.sv
module stop_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic req_i,
  input  logic busy_i,
  input  logic eof_i,
  output logic done_o
);
  logic pend_q, pend_d;
  logic done_q, done_d;

  always_comb begin
    if (wr_i) begin
      done_d = req_i & (~busy_i | eof_i);
      pend_d = req_i & busy_i & ~eof_i;
    end else begin
      done_d = pend_q & eof_i;
      pend_d = pend_q & ~eof_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R2 / R4: an idle path completes on the next cycle
  a_r2_immediate_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && req_i && !busy_i) |=> done_o);
  // R3: a pending stop completes after its end-of-frame pulse
  a_r3_deferred_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && pend_q && eof_i) |=> done_o);
  // R5 / R6: a pulse needs a request write or a pending stop
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_i && req_i) || $past(pend_q)));
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int unsigned PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_wop_i,
  input  logic wop_q_i,
  input  logic gts_q_i,
  output logic poll_o
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             poll_q, poll_d;
  logic             expire;

  assign expire = run_q && (cnt_q == '0);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    poll_d = 1'b0;
    if (wr_i && !wr_wop_i) begin
      run_d = 1'b1;
      cnt_d = RELOAD;
    end else if (expire) begin
      if (!wop_q_i) begin
        cnt_d  = RELOAD;
        poll_d = !gts_q_i;
      end else begin
        run_d = 1'b0;
      end
    end else if (run_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      poll_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      poll_q <= poll_d;
    end
  end

  assign poll_o = poll_q;

  // R8 / R9: a strobe only follows an expiry with both gating bits clear
  a_r8_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    poll_o |-> (!gts_q_i && !wop_q_i && $past(expire)));
  // R10: a restarting write suppresses the strobe of that cycle
  a_r10_restart_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wr_wop_i) |=> !poll_o);
  // R1: an idle timer emits nothing
  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_i) |=> !poll_o);
endmodule

// File: rtl/dma_stop_poll_ctrl.sv
module dma_stop_poll_ctrl #(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned POLL_HZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_gts,
  input  logic ctl_grs,
  input  logic ctl_wop,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic tx_eof,
  input  logic rx_eof,
  output logic tx_stop_done,
  output logic rx_stop_done,
  output logic poll_tx0
);
  import dma_stop_poll_pkg::*;

  localparam int unsigned PERIOD = (CLK_HZ / POLL_HZ < 2) ? 2 : CLK_HZ / POLL_HZ;

  dma_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d.tx_stop = ctl_gts;
      ctl_d.rx_stop = ctl_grs;
      ctl_d.no_poll = ctl_wop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  stop_unit u_tx_stop (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .req_i(ctl_gts),
    .busy_i(tx_busy), .eof_i(tx_eof), .done_o(tx_stop_done)
  );

  stop_unit u_rx_stop (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .req_i(ctl_grs),
    .busy_i(rx_busy), .eof_i(rx_eof), .done_o(rx_stop_done)
  );

  poll_timer #(.PERIOD(PERIOD)) u_poll (
    .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .wr_wop_i(ctl_wop),
    .wop_q_i(ctl_q.no_poll), .gts_q_i(ctl_q.tx_stop), .poll_o(poll_tx0)
  );
endmodule

// File: tb/tb_dma_stop_poll_ctrl.sv
module tb_dma_stop_poll_ctrl;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_gts = 0, ctl_grs = 0, ctl_wop = 0;
  logic tx_busy = 0, rx_busy = 0, tx_eof = 0, rx_eof = 0;
  logic tx_stop_done, rx_stop_done, poll_tx0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_stop_poll_ctrl #(.CLK_HZ(P * 100), .POLL_HZ(100)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_gts(ctl_gts),
    .ctl_grs(ctl_grs), .ctl_wop(ctl_wop), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .tx_eof(tx_eof), .rx_eof(rx_eof),
    .tx_stop_done(tx_stop_done), .rx_stop_done(rx_stop_done),
    .poll_tx0(poll_tx0)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic g, input logic r, input logic w);
    @(negedge clk);
    ctl_wr = 1; ctl_gts = g; ctl_grs = r; ctl_wop = w;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic pulse_eof(input bit tx);
    @(negedge clk);
    if (tx) tx_eof = 1; else rx_eof = 1;
    @(negedge clk);
    tx_eof = 0; rx_eof = 0;
  endtask

  // watches len cycles after the current negedge; returns strobe count and first/second index
  task automatic watch(input int len, output int cnt, output int first, output int second);
    cnt = 0; first = -1; second = -1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (poll_tx0) begin
        cnt++;
        if (first < 0) first = i; else if (second < 0) second = i;
      end
    end
  endtask

  task automatic t_reset();
    int c, f, s;
    check(!tx_stop_done && !rx_stop_done && !poll_tx0, "R1 outputs", 0, 0);
    watch(3 * P, c, f, s);
    check(c == 0, "R1 idle timer", c, 0);
  endtask

  task automatic t_rx_immediate();
    wr_ctl(0, 1, 1);
    check(rx_stop_done == 1, "R2 pulse", rx_stop_done, 1);
    check(tx_stop_done == 0, "R2 tx quiet", tx_stop_done, 0);
    @(negedge clk);
    check(rx_stop_done == 0, "R2 one cycle", rx_stop_done, 0);
  endtask

  task automatic t_rx_deferred();
    rx_busy = 1;
    wr_ctl(0, 1, 1);
    check(rx_stop_done == 0, "R3 no early pulse", rx_stop_done, 0);
    repeat (3) @(negedge clk);
    check(rx_stop_done == 0, "R3 waits", rx_stop_done, 0);
    pulse_eof(0);
    check(rx_stop_done == 1, "R3 pulse after eof", rx_stop_done, 1);
    @(negedge clk);
    check(rx_stop_done == 0, "R3 one cycle", rx_stop_done, 0);
    pulse_eof(0);
    check(rx_stop_done == 0, "R5 no second pulse", rx_stop_done, 0);
    rx_busy = 0;
  endtask

  task automatic t_tx_paths();
    wr_ctl(1, 0, 1);
    check(tx_stop_done == 1, "R4 tx immediate", tx_stop_done, 1);
    tx_busy = 1;
    wr_ctl(1, 0, 1);
    check(tx_stop_done == 0, "R4 tx deferred held", tx_stop_done, 0);
    pulse_eof(1);
    check(tx_stop_done == 1, "R4 tx deferred pulse", tx_stop_done, 1);
    @(negedge clk);
    check(tx_stop_done == 0, "R4 tx one cycle", tx_stop_done, 0);
    tx_busy = 0;
  endtask

  task automatic t_cancel();
    rx_busy = 1;
    wr_ctl(0, 1, 1);
    wr_ctl(0, 0, 1);
    pulse_eof(0);
    check(rx_stop_done == 0, "R6 withdrawn stop", rx_stop_done, 0);
    rx_busy = 0;
  endtask

  task automatic t_poll_period();
    int c, f, s;
    wr_ctl(0, 0, 0);
    watch(2 * P, c, f, s);
    check(f == P, "R7 first strobe", f, P);
    check(s == 2 * P, "R7 second strobe", s, 2 * P);
    check(c == 2, "R7 strobe count", c, 2);
  endtask

  task automatic t_restart();
    int c, f, s;
    repeat (P / 2) @(negedge clk);
    wr_ctl(0, 0, 0);
    watch(P, c, f, s);
    check(f == P && c == 1, "R10 restart", f, P);
  endtask

  task automatic t_gts_gate();
    int c, f, s;
    wr_ctl(1, 0, 0);
    check(tx_stop_done == 1, "R4 gts with idle tx", tx_stop_done, 1);
    watch(3 * P, c, f, s);
    check(c == 0, "R8 gated", c, 0);
    wr_ctl(0, 0, 0);
    watch(P, c, f, s);
    check(f == P, "R8 resumes", f, P);
  endtask

  task automatic t_wop_stop();
    int c, f, s;
    wr_ctl(0, 0, 1);
    watch(4 * P, c, f, s);
    check(c == 0, "R9 suppressed", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx_immediate();
    t_rx_deferred();
    t_tx_paths();
    t_cancel();
    t_poll_period();
    t_restart();
    t_gts_gate();
    t_wop_stop();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule